// File: doc/BRIEF.md
# Priority Winner Selector

This block looks at a vector of 64 interrupt requests, each with a 4-bit priority, and picks the one request that should be vectored next. Only requests with their active bit set take part. The request with the largest priority wins. When several requests share that priority, the one with the largest index wins. The block reports the winner as a valid flag, a 6-bit index and the winning priority. It also reports the same result as one 32-bit status word that software can read directly.

It also raises a threshold flag against a 5-bit mask. The flag goes high when any active request's priority is strictly above the mask. The mask value 31 is a special case: with that mask, any active request raises the flag. The surrounding controller holds the request, enable and priority registers, decodes the bus, and clears the request that was taken. This block only does the arbitration. It is a two-stage comparison tree, so every output appears a fixed two clock edges after its inputs.

Top module: `prio_pick`

## Requirements
- R1: Only sources whose bit in `req_i` is 1 can win. `valid_o` is 1 exactly when at least one request bit is set.
- R2: The winner is the active source with the numerically largest priority. Source i's priority sits in `pri_i[4*i+3:4*i]`. `pri_o` reports the winner's priority.
- R3: When several active sources share the largest priority, `idx_o` is the largest source number among them.
- R4: Every priority value, including 0, can win when its source is active.
- R5: With a winner, `status_o[31:16]` holds the index zero-extended, `status_o[15:4]` is zero and `status_o[3:0]` holds the priority.
- R6: With no active source, `status_o` is 32'hFFFFFFFF.
- R7: `thr_o` is 1 when `mask_i` is 31 and some source is active, or when some active source's priority is strictly greater than `mask_i`. Otherwise it is 0.
- R8: All outputs reflect the inputs sampled two rising clock edges earlier. A new input set may be applied every cycle.
- R9: A synchronous reset forces `valid_o`=0, `idx_o`=0, `pri_o`=0, `thr_o`=0 and `status_o`=32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Active-request vector, one bit per source |
| pri_i | input | 256 | Packed 4-bit priorities, source i in bits 4i+3:4i |
| mask_i | input | 5 | Threshold mask |
| valid_o | output | 1 | A winner exists |
| idx_o | output | 6 | Winning source number |
| pri_o | output | 4 | Winning priority |
| status_o | output | 32 | Packed index and priority, or all ones when idle |
| thr_o | output | 1 | Threshold-exceeded flag |

## Verification
The bench targets the following corner cases, each with the wrong result it would catch:
- **All 64 sources active at one priority.** A tie-break that favours low numbers would report index 0 instead of 63.
- **A single active source at priority 0.** A design that treats 0 as "no request" would drop `valid_o`.
- **A high-priority inactive source placed next to weaker active ones.** Forgetting the request mask would let the inactive source win.
- **Mask equal to a priority, and mask equal to 31.** These expose a `>=` comparison used in place of `>`, and a missing special case for mask 31. The same mask-31 test with no requests also catches a flag raised while idle.
- **Results streamed back to back.** Any off-by-one in the pipeline would misalign every result.

// File: rtl/prio_pick_pkg.sv
package prio_pick_pkg;

    localparam int NSRC   = 64;
    localparam int GRP    = 8;
    localparam int PRI_W  = 4;
    localparam int MASK_W = 5;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int STAT_W = 32;
    localparam int HALF_W = STAT_W / 2;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [PRI_W-1:0] pri;
    } cand_t;

    // Candidates are offered in ascending index order; a later one of equal
    // priority displaces the holder, so ties settle on the higher index.
    function automatic cand_t pick(cand_t challenger, cand_t holder);
        if (challenger.vld && (!holder.vld || challenger.pri >= holder.pri))
            return challenger;
        return holder;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(cand_t c);
        logic [STAT_W-1:0] s;
        if (!c.vld) begin
            s = '1;
        end else begin
            s = '0;
            s[STAT_W-1:HALF_W] = HALF_W'(c.idx);
            s[PRI_W-1:0]       = c.pri;
        end
        return s;
    endfunction

endpackage

// File: rtl/prio_pick_group.sv
module prio_pick_group
    import prio_pick_pkg::*;
#(
    parameter int GRP_SZ = GRP,
    parameter int BASE   = 0
) (
    input  logic [GRP_SZ-1:0]       req_i,
    input  logic [GRP_SZ*PRI_W-1:0] pri_i,
    input  logic [MASK_W-1:0]       mask_i,
    output cand_t                   best_o,
    output logic                    above_o
);

    always_comb begin
        cand_t c;
        best_o  = '0;
        above_o = 1'b0;
        for (int i = 0; i < GRP_SZ; i++) begin
            c.vld  = req_i[i];
            c.idx  = IDX_W'(BASE + i);
            c.pri  = pri_i[i*PRI_W +: PRI_W];
            best_o = pick(c, best_o);
            if (req_i[i] && (MASK_W'(c.pri) > mask_i))
                above_o = 1'b1;
        end
    end

endmodule

// File: rtl/prio_pick_merge.sv
module prio_pick_merge
    import prio_pick_pkg::*;
#(
    parameter int N_GRP = NSRC / GRP
) (
    input  cand_t             grp_c   [N_GRP],
    input  logic [N_GRP-1:0]  grp_above,
    input  logic              mask_max,
    output cand_t             win_o,
    output logic              thr_o
);

    always_comb begin
        win_o = '0;
        for (int g = 0; g < N_GRP; g++)
            win_o = pick(grp_c[g], win_o);
        thr_o = (|grp_above) | (mask_max & win_o.vld);
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import prio_pick_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int GRP_SZ = GRP
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        req_i,
    input  logic [N_SRC*PRI_W-1:0]  pri_i,
    input  logic [MASK_W-1:0]       mask_i,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic [PRI_W-1:0]        pri_o,
    output logic [STAT_W-1:0]       status_o,
    output logic                    thr_o
);

    localparam int N_GRP = N_SRC / GRP_SZ;

    cand_t            grp_c   [N_GRP];
    logic [N_GRP-1:0] grp_above;
    cand_t            s1_c    [N_GRP];
    logic [N_GRP-1:0] s1_above;
    logic             s1_maxm;
    cand_t            win;
    logic             thr_n;

    // Stage 1: one leaf scan per group, registered.
    for (genvar g = 0; g < N_GRP; g++) begin : g_leaf
        prio_pick_group #(.GRP_SZ(GRP_SZ), .BASE(g*GRP_SZ)) u_grp (
            .req_i   (req_i[g*GRP_SZ +: GRP_SZ]),
            .pri_i   (pri_i[g*GRP_SZ*PRI_W +: GRP_SZ*PRI_W]),
            .mask_i  (mask_i),
            .best_o  (grp_c[g]),
            .above_o (grp_above[g])
        );

        always_ff @(posedge clk) begin
            if (rst) s1_c[g] <= '0;
            else     s1_c[g] <= grp_c[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_above <= '0;
            s1_maxm  <= 1'b0;
        end else begin
            s1_above <= grp_above;
            s1_maxm  <= &mask_i;
        end
    end

    // Stage 2: merge the group winners, registered at the outputs.
    prio_pick_merge #(.N_GRP(N_GRP)) u_merge (
        .grp_c     (s1_c),
        .grp_above (s1_above),
        .mask_max  (s1_maxm),
        .win_o     (win),
        .thr_o     (thr_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            idx_o    <= '0;
            pri_o    <= '0;
            status_o <= '1;
            thr_o    <= 1'b0;
        end else begin
            valid_o  <= win.vld;
            idx_o    <= win.idx;
            pri_o    <= win.pri;
            status_o <= pack_status(win);
            thr_o    <= thr_n;
        end
    end

    // Cycles since reset, so that two-deep history checks start clean.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    AST_IDLE_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> status_o == '1); // R6

    AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (status_o[STAT_W-1:HALF_W] == HALF_W'(idx_o)) &&
                    (status_o[HALF_W-1:PRI_W] == '0) &&
                    (status_o[PRI_W-1:0] == pri_o)); // R5

    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (valid_o && warm == 2'd2) |-> (($past(req_i, 2) >> idx_o) & 1) != 0); // R1

    AST_WINNER_PRI: assert property (@(posedge clk) disable iff (rst)
        (valid_o && warm == 2'd2) |->
            PRI_W'($past(pri_i, 2) >> (idx_o * PRI_W)) == pri_o); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> valid_o == ($past(req_i, 2) != '0)); // R8

    AST_THR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        thr_o |-> valid_o); // R7

endmodule

// File: tb/sim_prio_pick.sv
module sim_prio_pick;

    localparam int NS = 320;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [63:0]  req_i = '0;
    logic [255:0] pri_i = '0;
    logic [4:0]   mask_i = '0;
    logic         valid_o;
    logic [5:0]   idx_o;
    logic [3:0]   pri_o;
    logic [31:0]  status_o;
    logic         thr_o;

    always #10 clk = ~clk;

    prio_pick u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .pri_i(pri_i), .mask_i(mask_i),
        .valid_o(valid_o), .idx_o(idx_o), .pri_o(pri_o),
        .status_o(status_o), .thr_o(thr_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Directed table: stimulus and expected winner.
    localparam int NT = 8;
    localparam logic [63:0] T_REQ [NT] = '{
        64'h0,
        64'h1 << 5,
        '1,
        '1,
        (64'h1 << 3) | (64'h1 << 40),
        (64'h1 << 10) | (64'h1 << 20) | (64'h1 << 30),
        64'h0,
        (64'h1 << 0) | (64'h1 << 63)
    };
    localparam logic [255:0] T_PRI [NT] = '{
        '1,
        256'h0,
        {64{4'h7}},
        {64{4'h7}},
        (256'h9 << 12) | (256'h2 << 160) | (256'hF << 200),
        {64{4'hC}},
        '1,
        (256'h5 << 0) | (256'h4 << 252)
    };
    localparam logic [4:0] T_MASK [NT] = '{5'd0, 5'd31, 5'd6, 5'd7, 5'd8, 5'd30, 5'd31, 5'd4};
    localparam logic       T_VLD  [NT] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [5:0] T_IDX  [NT] = '{6'd0, 6'd5, 6'd63, 6'd63, 6'd3, 6'd30, 6'd0, 6'd0};
    localparam logic [3:0] T_PRIO [NT] = '{4'd0, 4'd0, 4'd7, 4'd7, 4'd9, 4'hC, 4'd0, 4'd5};
    localparam logic       T_THR  [NT] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic [63:0]  s_req  [NS];
    logic [255:0] s_pri  [NS];
    logic [4:0]   s_mask [NS];
    logic         e_vld  [NS];
    logic [5:0]   e_idx  [NS];
    logic [3:0]   e_pri  [NS];
    logic         e_thr  [NS];

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Reference: scan from the top index down, keep the first strict maximum.
    task automatic ref_scan(input logic [63:0] rq, input logic [255:0] pr,
                            input logic [4:0] mk, output logic v,
                            output logic [5:0] ix, output logic [3:0] p,
                            output logic th);
        v = 1'b0; ix = '0; p = '0; th = 1'b0;
        for (int i = 63; i >= 0; i--) begin
            if (rq[i]) begin
                if (!v || pr[4*i +: 4] > p) begin
                    v = 1'b1; ix = 6'(i); p = pr[4*i +: 4];
                end
                if ({1'b0, pr[4*i +: 4]} > mk) th = 1'b1;
            end
        end
        if (v && mk == 5'd31) th = 1'b1;
    endtask

    task automatic check_row(int j);
        logic [31:0] st;
        st = e_vld[j] ? {10'd0, e_idx[j], 12'd0, e_pri[j]} : 32'hFFFF_FFFF;
        check($sformatf("R1 valid row %0d", j), 32'(valid_o), 32'(e_vld[j]));
        if (e_vld[j]) begin
            check($sformatf("R3 R2 R4 index row %0d", j), 32'(idx_o), 32'(e_idx[j]));
            check($sformatf("R2 priority row %0d", j), 32'(pri_o), 32'(e_pri[j]));
        end
        check($sformatf("R5 R6 status row %0d", j), status_o, st);
        check($sformatf("R7 threshold row %0d", j), 32'(thr_o), 32'(e_thr[j]));
    endtask

    // R8: row k is driven at negedge k and checked at negedge k+2.
    task automatic stream(int n);
        for (int k = 0; k < n + 2; k++) begin
            @(negedge clk);
            if (k >= 2) check_row(k - 2);
            if (k < n) begin
                req_i = s_req[k]; pri_i = s_pri[k]; mask_i = s_mask[k];
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: state right after reset
        check("R9 reset valid",  32'(valid_o), 32'd0);
        check("R9 reset index",  32'(idx_o),   32'd0);
        check("R9 reset pri",    32'(pri_o),   32'd0);
        check("R9 reset status", status_o,     32'hFFFF_FFFF);
        check("R9 reset thr",    32'(thr_o),   32'd0);

        for (int t = 0; t < NT; t++) begin
            s_req[t] = T_REQ[t]; s_pri[t] = T_PRI[t]; s_mask[t] = T_MASK[t];
            e_vld[t] = T_VLD[t]; e_idx[t] = T_IDX[t];
            e_pri[t] = T_PRIO[t]; e_thr[t] = T_THR[t];
        end
        stream(NT);

        for (int t = 0; t < NS; t++) begin
            logic [3:0] same;
            s_req[t] = {$urandom(), $urandom()};
            if (t % 5 == 1) s_req[t] = s_req[t] & {$urandom(), $urandom()} & {$urandom(), $urandom()};
            if (t % 11 == 3) s_req[t] = '0;
            if (t % 4 == 0) begin
                same = 4'($urandom());
                s_pri[t] = {64{same}};
            end else begin
                for (int w = 0; w < 8; w++) s_pri[t][32*w +: 32] = $urandom();
            end
            s_mask[t] = (t % 7 == 0) ? 5'd31 : 5'($urandom());
            ref_scan(s_req[t], s_pri[t], s_mask[t], e_vld[t], e_idx[t], e_pri[t], e_thr[t]);
        end
        stream(NS);

        // R9: reset in the middle of activity clears the outputs
        req_i = '1; pri_i = {64{4'hA}}; mask_i = 5'd0;
        repeat (3) @(negedge clk);
        check("R9 busy before reset", 32'(valid_o), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset valid",  32'(valid_o), 32'd0);
        check("R9 mid reset status", status_o,     32'hFFFF_FFFF);
        check("R9 mid reset thr",    32'(thr_o),   32'd0);
        check("R9 mid reset index",  32'(idx_o),   32'd0);
        rst = 1'b0;
        req_i = '0;
        repeat (3) @(negedge clk);
        check("R6 idle after reset status", status_o, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule